// File: doc/BRIEF.md
# VGA Planar Read Converter

This block turns one 32-bit frame buffer word, held as four 8-bit planes, into the single byte a host read returns. It has two ways to reduce the word. In the first, it returns one plane's byte. The plane comes from a plane select value, or from the low address bits when a chained addressing mode is active. In the second, it builds a one-bit-per-pixel match mask. Each result bit reports whether every participating plane holds the programmed colour at that bit position.

The result is registered. It appears one clock after a read strobe, together with a one-cycle valid flag. Between strobes the returned byte holds its last value. Loading the frame buffer word, decoding the address and everything on the write side belong to neighbouring logic.

Top module: `vga_rd_conv`

## Requirements
- R1: While `rst_n` is low and after its release, `rd_valid` is 0 and `rd_data` is 8'h00 until the first strobe.
- R2: A high `rd_stb` sampled on a rising edge makes `rd_valid` 1 for exactly the next cycle. Without a strobe, `rd_valid` is 0 and `rd_data` keeps its previous value whatever the other inputs do.
- R3: With `rd_mode`=0 and neither chain flag set, `rd_data` is plane `plane_sel` of `fb_word`. Plane p occupies bits [8p+7:8p].
- R4: With `rd_mode`=0 and `chain4_en`=1, the plane index is `addr_lo[1:0]` and `plane_sel` is not used.
- R5: With `rd_mode`=0, `oddeven_en`=1 and `chain4_en`=0, the plane index is {`plane_sel[1]`, `addr_lo[0]`}.
- R6: When both `chain4_en` and `oddeven_en` are 1, the four-way chained rule of R4 applies.
- R7: With `rd_mode`=1, bit n of `rd_data` is 1 only when, for every plane b that takes part, bit n of plane b equals `cmp_color[b]`.
- R8: A plane b with `cmp_skip[b]`=1 takes no part in the R7 comparison.
- R9: With `rd_mode`=1 and `cmp_skip`=4'hF, `rd_data` is 8'hFF.
- R10: In mode 0, `cmp_color` and `cmp_skip` do not affect `rd_data`. In mode 1, `plane_sel`, `addr_lo` and the chain flags do not affect `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| fb_word | input | 32 | Frame buffer word, four 8-bit planes |
| addr_lo | input | 2 | Low host address bits |
| rd_mode | input | 1 | 0 = plane byte, 1 = colour match mask |
| plane_sel | input | 2 | Plane index for mode 0 |
| chain4_en | input | 1 | Four-way chained addressing |
| oddeven_en | input | 1 | Two-way chained addressing |
| cmp_color | input | 4 | Colour value, one bit per plane |
| cmp_skip | input | 4 | Per-plane exclusion from the match |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | High the cycle after a strobe |

## Verification
The hard case is the mode 1 result when only some planes are excluded. The result then depends jointly on colour, exclusion mask and data, and a mistake in one plane only shows for particular bit patterns. The bench therefore sweeps all 256 colour/exclusion pairs against several data words whose planes differ bit by bit. For mode 0 it sweeps every combination of plane select, address and chain flags. Meanwhile the unused controls are scrambled, and idle cycles with changed inputs test the hold behaviour.

// File: rtl/vga_rdc_pkg.sv
package vga_rdc_pkg;
  typedef enum logic {
    RDM_PLANE = 1'b0,
    RDM_MATCH = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/vga_rdc_plane_steer.sv
module vga_rdc_plane_steer #(
  parameter int PLANES = 4,
  localparam int SEL_W = $clog2(PLANES)
) (
  input  logic [SEL_W-1:0] plane_sel,
  input  logic [SEL_W-1:0] addr_lo,
  input  logic             chain4_en,
  input  logic             oddeven_en,
  output logic [SEL_W-1:0] eff_plane
);
  // Four-way chaining wins; two-way chaining swaps in address bit 0.
  function automatic logic [SEL_W-1:0] steer(
    input logic [SEL_W-1:0] sel, input logic [SEL_W-1:0] adr,
    input logic c4, input logic oe);
    logic [SEL_W-1:0] r;
    r = sel;
    if (c4)      r = adr;
    else if (oe) r[0] = adr[0];
    return r;
  endfunction

  always_comb eff_plane = steer(plane_sel, addr_lo, chain4_en, oddeven_en);
endmodule

// File: rtl/vga_rdc_plane_mux.sv
module vga_rdc_plane_mux #(
  parameter int PLANES  = 4,
  parameter int PLANE_W = 8,
  localparam int SEL_W  = $clog2(PLANES),
  localparam int WORD_W = PLANES * PLANE_W
) (
  input  logic [WORD_W-1:0]  fb_word,
  input  logic [SEL_W-1:0]   idx,
  output logic [PLANE_W-1:0] plane_byte
);
  logic [PLANE_W-1:0] planes [PLANES];

  for (genvar p = 0; p < PLANES; p++) begin : g_split
    assign planes[p] = fb_word[p*PLANE_W +: PLANE_W];
  end

  always_comb plane_byte = planes[idx];
endmodule

// File: rtl/vga_rdc_color_match.sv
module vga_rdc_color_match #(
  parameter int PLANES  = 4,
  parameter int PLANE_W = 8,
  localparam int WORD_W = PLANES * PLANE_W
) (
  input  logic [WORD_W-1:0]  fb_word,
  input  logic [PLANES-1:0]  cmp_color,
  input  logic [PLANES-1:0]  cmp_skip,
  output logic [PLANE_W-1:0] match_mask
);
  // A plane passes at a bit when it is skipped or agrees with its colour bit.
  function automatic logic plane_ok(input logic data_bit, input logic color_bit,
                                    input logic skip_bit);
    return skip_bit | ~(data_bit ^ color_bit);
  endfunction

  for (genvar n = 0; n < PLANE_W; n++) begin : g_bit
    logic [PLANES-1:0] ok;
    for (genvar b = 0; b < PLANES; b++) begin : g_plane
      assign ok[b] = plane_ok(fb_word[b*PLANE_W + n], cmp_color[b], cmp_skip[b]);
    end
    assign match_mask[n] = &ok;
  end
endmodule

// File: rtl/vga_rd_conv.sv
module vga_rd_conv #(
  parameter int PLANES  = 4,
  parameter int PLANE_W = 8,
  localparam int SEL_W  = $clog2(PLANES),
  localparam int WORD_W = PLANES * PLANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  logic [WORD_W-1:0]  fb_word,
  input  logic [SEL_W-1:0]   addr_lo,
  input  logic               rd_mode,
  input  logic [SEL_W-1:0]   plane_sel,
  input  logic               chain4_en,
  input  logic               oddeven_en,
  input  logic [PLANES-1:0]  cmp_color,
  input  logic [PLANES-1:0]  cmp_skip,
  output logic [PLANE_W-1:0] rd_data,
  output logic               rd_valid
);
  import vga_rdc_pkg::*;

  rd_mode_e           mode;
  logic [SEL_W-1:0]   eff_plane;
  logic [PLANE_W-1:0] plane_byte;
  logic [PLANE_W-1:0] match_mask;
  logic [PLANE_W-1:0] next_byte;

  assign mode = rd_mode_e'(rd_mode);

  vga_rdc_plane_steer #(.PLANES(PLANES)) u_steer (
    .plane_sel (plane_sel),
    .addr_lo   (addr_lo),
    .chain4_en (chain4_en),
    .oddeven_en(oddeven_en),
    .eff_plane (eff_plane)
  );

  vga_rdc_plane_mux #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_mux (
    .fb_word   (fb_word),
    .idx       (eff_plane),
    .plane_byte(plane_byte)
  );

  vga_rdc_color_match #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_match (
    .fb_word   (fb_word),
    .cmp_color (cmp_color),
    .cmp_skip  (cmp_skip),
    .match_mask(match_mask)
  );

  always_comb next_byte = (mode == RDM_MATCH) ? match_mask : plane_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= next_byte;
    end
  end
endmodule

// File: rtl/vga_rd_conv_chk.sv
module vga_rd_conv_chk #(
  parameter int PLANES  = 4,
  parameter int PLANE_W = 8,
  localparam int SEL_W  = $clog2(PLANES),
  localparam int WORD_W = PLANES * PLANE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_stb,
  input logic [WORD_W-1:0]  fb_word,
  input logic [SEL_W-1:0]   addr_lo,
  input logic               rd_mode,
  input logic [SEL_W-1:0]   plane_sel,
  input logic               chain4_en,
  input logic               oddeven_en,
  input logic [PLANES-1:0]  cmp_skip,
  input logic [SEL_W-1:0]   eff_plane,
  input logic [PLANE_W-1:0] rd_data,
  input logic               rd_valid
);
  logic [PLANE_W-1:0] addr_byte;
  always_comb addr_byte = fb_word[addr_lo*PLANE_W +: PLANE_W];

  a_r2_valid_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (!rd_valid && $stable(rd_data)));
  a_r3_plain_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain4_en && !oddeven_en) |-> eff_plane == plane_sel);
  a_r4_chain4_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_mode && chain4_en) |=> rd_data == $past(addr_byte));
  a_r5_oddeven_select: assert property (@(posedge clk) disable iff (!rst_n)
    (oddeven_en && !chain4_en) |->
      (eff_plane[0] == addr_lo[0] && eff_plane[SEL_W-1] == plane_sel[SEL_W-1]));
  a_r6_chain4_wins: assert property (@(posedge clk) disable iff (!rst_n)
    chain4_en |-> eff_plane == addr_lo);
  a_r9_all_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_mode && (&cmp_skip)) |=> rd_data == {PLANE_W{1'b1}});
endmodule

bind vga_rd_conv vga_rd_conv_chk #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_stb    (rd_stb),
  .fb_word   (fb_word),
  .addr_lo   (addr_lo),
  .rd_mode   (rd_mode),
  .plane_sel (plane_sel),
  .chain4_en (chain4_en),
  .oddeven_en(oddeven_en),
  .cmp_skip  (cmp_skip),
  .eff_plane (eff_plane),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid)
);

// File: tb/vga_rd_conv_tb.sv
`timescale 1ns/1ps
module vga_rd_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_stb = 1'b0;
  logic [31:0] fb_word = '0;
  logic [1:0]  addr_lo = '0;
  logic        rd_mode = 1'b0;
  logic [1:0]  plane_sel = '0;
  logic        chain4_en = 1'b0;
  logic        oddeven_en = 1'b0;
  logic [3:0]  cmp_color = '0;
  logic [3:0]  cmp_skip = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vga_rd_conv u_dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .fb_word(fb_word),
    .addr_lo(addr_lo), .rd_mode(rd_mode), .plane_sel(plane_sel),
    .chain4_en(chain4_en), .oddeven_en(oddeven_en), .cmp_color(cmp_color),
    .cmp_skip(cmp_skip), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_plane(input logic [31:0] w, input logic [1:0] sel,
                                           input logic [1:0] adr, input bit c4, input bit oe);
    int p;
    if (c4)      p = adr;
    else if (oe) p = (sel & 2) | (adr & 1);
    else         p = sel;
    return 8'((w >> (8 * p)) & 32'hFF);
  endfunction

  function automatic logic [7:0] exp_match(input logic [31:0] w, input logic [3:0] col,
                                           input logic [3:0] skp);
    logic [7:0] r;
    for (int n = 0; n < 8; n++) begin
      r[n] = 1'b1;
      for (int b = 0; b < 4; b++)
        if (!skp[b] && (w[8*b+n] != col[b])) r[n] = 1'b0;
    end
    return r;
  endfunction

  // Strobe at a falling edge, sample at the next falling edge.
  task automatic do_read(input logic [7:0] exp, input string req);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check(rd_valid === 1'b1, "R2 valid", int'(rd_valid), 1);
    check(rd_data === exp, req, int'(rd_data), int'(exp));
  endtask

  initial begin
    logic [31:0] words [3];
    logic [7:0]  held;
    string       tag;
    words[0] = 32'h0F3C_A55A;
    words[1] = 32'hFFFF_0000;
    words[2] = 32'h1234_5678;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(rd_valid === 1'b0 && rd_data === 8'h00, "R1 during reset", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid === 1'b0 && rd_data === 8'h00, "R1 after release", int'(rd_data), 0);

    // Mode 0 sweep: R3/R4/R5/R6, compare controls scrambled for R10
    rd_mode = 1'b0;
    for (int w = 0; w < 3; w++) begin
      for (int k = 0; k < 64; k++) begin
        fb_word    = words[w];
        plane_sel  = 2'(k);
        addr_lo    = 2'(k >> 2);
        chain4_en  = k[4];
        oddeven_en = k[5];
        cmp_color  = 4'(k * 7 + w);
        cmp_skip   = 4'(k * 3);
        if (chain4_en && oddeven_en) tag = "R6 chain4 priority (R10)";
        else if (chain4_en)          tag = "R4 chain4 plane (R10)";
        else if (oddeven_en)         tag = "R5 oddeven plane (R10)";
        else                         tag = "R3 plane select (R10)";
        do_read(exp_plane(words[w], plane_sel, addr_lo, chain4_en, oddeven_en), tag);
      end
    end

    // Mode 1 sweep: R7/R8/R9, steering inputs scrambled for R10
    rd_mode = 1'b1;
    for (int w = 0; w < 3; w++) begin
      for (int k = 0; k < 256; k++) begin
        fb_word    = words[w];
        cmp_color  = 4'(k);
        cmp_skip   = 4'(k >> 4);
        plane_sel  = 2'(k * 5);
        addr_lo    = 2'(k * 3 + w);
        chain4_en  = k[1];
        oddeven_en = k[2];
        if (cmp_skip == 4'hF)      tag = "R9 all planes skipped (R10)";
        else if (cmp_skip != 4'h0) tag = "R8 partial skip (R10)";
        else                       tag = "R7 colour match (R10)";
        do_read(exp_match(words[w], cmp_color, cmp_skip), tag);
      end
    end

    // R2 hold: idle cycles with every input changed
    held = rd_data;
    for (int k = 0; k < 4; k++) begin
      fb_word   = ~fb_word;
      rd_mode   = ~rd_mode;
      cmp_color = ~cmp_color;
      plane_sel = plane_sel + 2'd1;
      @(negedge clk);
      check(rd_valid === 1'b0, "R2 idle valid", int'(rd_valid), 0);
      check(rd_data === held, "R2 idle hold", int'(rd_data), int'(held));
    end

    // R2 back-to-back strobes
    rd_mode = 1'b0; chain4_en = 1'b1; oddeven_en = 1'b0; fb_word = 32'hDDCC_BBAA;
    addr_lo = 2'd3;
    do_read(8'hDD, "R4 back-to-back first");
    addr_lo = 2'd1;
    do_read(8'hBB, "R4 back-to-back second");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule